// File: doc/BRIEF.md
# T1/E1 Receive Sync Pulse Generator

This block produces the receive-side timing marks for a T1 or E1 receive framer. An upstream framer supplies a bit position counter and frame position indices, all advancing on the recovered bit clock. From these, the block drives two outputs. `sync_out` is a configurable main sync pulse. `mfsync_out` is a dedicated multiframe marker.

Configuration inputs control the main pulse:
- It can mark every frame or only multiframes.
- In T1 multiframe mode it can be thinned to every other multiframe.
- In T1 frame mode it can be widened to two bit clocks in signaling frames.
- In E1 multiframe mode it can follow either the CAS or the CRC-4 multiframe.
- Its polarity can be inverted.

In E1 mode the multiframe marker follows the CAS/CRC-4 choice regardless of how the main pulse is set up. In T1 mode it marks superframe starts.

Two small state machines shape the pulses.
- **Skip FSM.** Its states are `SK_EMIT` and `SK_HOLD`. Each T1 multiframe start, while skipping is active, toggles EMIT→HOLD or HOLD→EMIT. A fresh enable of the skip bit (the arm transition) forces `SK_EMIT`.
- **Pulse FSM.** Its states are `PS_IDLE`, `PS_SINGLE`, `PS_WIDE_1` and `PS_WIDE_2`. A fire event moves it to `PS_SINGLE`, or to `PS_WIDE_1` when widening applies. `PS_WIDE_1` always advances to `PS_WIDE_2`. Any other state returns to `PS_IDLE` when there is no fire. A fire takes priority in every state.

Top module: `rx_sync_pulse_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next values are `mfsync_out` = 0 and `sync_out` = `cfg_invert`, which is the inactive level.
- R2: With `cfg_mf_mode` = 0, the main pulse goes active for one bit clock, in the cycle after the edge that samples `bit_pos` = 0. This holds in both T1 (`e1_mode` = 0) and E1 (`e1_mode` = 1).
- R3: With T1 and `cfg_mf_mode` = 1, the main pulse occurs only when `bit_pos` = 0 and `frame_idx` = 0 are sampled together.
- R4: With T1, multiframe mode and `cfg_skip` = 1, the main pulse appears on alternate multiframes. A 0→1 change of `cfg_skip` makes the next multiframe emit.
- R5: When `elastic_en` = 1, skipping is off and every T1 multiframe start produces a main pulse.
- R6: With T1, frame mode and `cfg_sel2` = 1, the pulse lasts two bit clocks in signaling frames. Signaling frames are `frame_idx` 5 and 11 when `esf_mode` = 0, and 5, 11, 17 and 23 when `esf_mode` = 1. Other frames, and every case with `cfg_sel2` = 0 or E1 mode, give one-clock pulses.
- R7: With E1 and multiframe mode, the main pulse marks frames with `cas_mf_index` = 0 when `cfg_sel2` = 0, and frames with `crc4_mf_index` = 0 when `cfg_sel2` = 1.
- R8: In E1, `mfsync_out` pulses for one clock at `bit_pos` = 0 of the multiframe chosen by `cfg_sel2`, whatever the main-pulse mode. In T1 it pulses at `bit_pos` = 0 of `frame_idx` = 0.
- R9: With `cfg_invert` = 1, `sync_out` is low when active and high when idle. `mfsync_out` is never inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive bit clock |
| rst | input | 1 | Synchronous reset, active high |
| e1_mode | input | 1 | 0 = T1 line, 1 = E1 line |
| esf_mode | input | 1 | T1 framing: 0 = 12-frame superframe, 1 = 24-frame extended superframe |
| bit_pos | input | 8 | Bit position within the current frame, 0 = first bit |
| frame_idx | input | 5 | T1 frame index within the superframe, 0-based |
| cas_mf_index | input | 4 | E1 frame index within the CAS multiframe |
| crc4_mf_index | input | 4 | E1 frame index within the CRC-4 multiframe |
| cfg_mf_mode | input | 1 | Main pulse rate: 0 = per frame, 1 = per multiframe |
| cfg_skip | input | 1 | T1 multiframe mode: pulse every other multiframe |
| cfg_sel2 | input | 1 | T1 frame mode: widen in signaling frames; E1: 0 = CAS, 1 = CRC-4 |
| cfg_invert | input | 1 | Invert the main sync output |
| elastic_en | input | 1 | Receive elastic store enabled flag (disables skipping) |
| sync_out | output | 1 | Main sync pulse, registered |
| mfsync_out | output | 1 | Dedicated multiframe sync pulse, registered |

## Verification
The bench builds the block with its default parameters. These are a 256-bit E1 frame, a 193-bit T1 frame, a 24-frame extended superframe, a signaling period of six frames and 16-frame E1 multiframes. With these values the bench can reach frame indices 17 and 23, which exist only in the extended superframe. It can also check that the 12-frame superframe does not widen those frames. Every state of both FSMs is visited, including the `SK_HOLD`→arm→`SK_EMIT` path and the `PS_WIDE_1`→`PS_WIDE_2` sequence.

// File: rtl/rsync_pkg.sv
package rsync_pkg;

    // Main/multiframe pulse shaper states
    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_SINGLE = 2'd1,
        PS_WIDE_1 = 2'd2,
        PS_WIDE_2 = 2'd3
    } pulse_state_t;

    // Every-other-multiframe phase
    typedef enum logic {
        SK_EMIT = 1'b0,
        SK_HOLD = 1'b1
    } skip_state_t;

    // Line standard
    typedef enum logic {
        LINE_T1 = 1'b0,
        LINE_E1 = 1'b1
    } line_t;

endpackage

// File: rtl/rsync_boundary_dec.sv
module rsync_boundary_dec #(
    parameter int BIT_W       = 8,
    parameter int FIDX_W      = 5,
    parameter int MFIDX_W     = 4,
    parameter int SIG_PERIOD  = 6,
    parameter int SF_FRAMES   = 12,
    parameter int ESF_FRAMES  = 24
) (
    input  logic [BIT_W-1:0]   bit_pos,
    input  logic [FIDX_W-1:0]  frame_idx,
    input  logic               esf_mode,
    input  logic [MFIDX_W-1:0] cas_idx,
    input  logic [MFIDX_W-1:0] crc_idx,
    input  logic               sel_crc4,
    output logic               frame_start,
    output logic               t1_mf_start,
    output logic               t1_sig_frame,
    output logic               e1_mf_start
);

    localparam int N_SIG = ESF_FRAMES / SIG_PERIOD;

    logic [N_SIG-1:0] sig_hit;

    // One comparator per possible signaling frame; frames beyond the
    // short superframe only count when the extended format is chosen.
    for (genvar k = 0; k < N_SIG; k++) begin : g_sig
        localparam int SIG_IDX  = (k + 1) * SIG_PERIOD - 1;
        localparam bit IN_SHORT = ((k + 1) * SIG_PERIOD) <= SF_FRAMES;
        if (IN_SHORT) begin : g_both
            assign sig_hit[k] = (frame_idx == FIDX_W'(SIG_IDX));
        end else begin : g_ext
            assign sig_hit[k] = esf_mode && (frame_idx == FIDX_W'(SIG_IDX));
        end
    end

    always_comb begin
        frame_start  = (bit_pos == '0);
        t1_mf_start  = frame_start && (frame_idx == '0);
        t1_sig_frame = |sig_hit;
        e1_mf_start  = frame_start && (sel_crc4 ? (crc_idx == '0) : (cas_idx == '0));
    end

endmodule

// File: rtl/rsync_skip_fsm.sv
module rsync_skip_fsm
    import rsync_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic skip_cfg,
    input  logic skip_active,
    input  logic mf_start,
    output logic allow
);

    skip_state_t state_q, state_d;
    logic        skip_prev_q;
    logic        arm;
    skip_state_t phase_eff;

    // A fresh enable of the skip bit re-arms the emit phase
    assign arm       = skip_cfg && !skip_prev_q;
    assign phase_eff = arm ? SK_EMIT : state_q;

    always_comb begin
        state_d = phase_eff;
        if (mf_start && skip_active) begin
            unique case (phase_eff)
                SK_EMIT: state_d = SK_HOLD;
                SK_HOLD: state_d = SK_EMIT;
                default: state_d = SK_EMIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SK_EMIT;
            skip_prev_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            skip_prev_q <= skip_cfg;
        end
    end

    assign allow = !skip_active || (phase_eff == SK_EMIT);

endmodule

// File: rtl/rsync_pulse_fsm.sv
module rsync_pulse_fsm
    import rsync_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic wide,
    input  logic invert,
    output logic pulse_out
);

    pulse_state_t state_q, state_d;

    always_comb begin
        state_d = PS_IDLE;
        if (fire) begin
            state_d = wide ? PS_WIDE_1 : PS_SINGLE;
        end else begin
            unique case (state_q)
                PS_IDLE:   state_d = PS_IDLE;
                PS_SINGLE: state_d = PS_IDLE;
                PS_WIDE_1: state_d = PS_WIDE_2;
                PS_WIDE_2: state_d = PS_IDLE;
                default:   state_d = PS_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_IDLE;
        else     state_q <= state_d;
    end

    // Registered output, polarity applied on the way in
    always_ff @(posedge clk) begin
        if (rst) pulse_out <= invert;
        else     pulse_out <= (state_d != PS_IDLE) ^ invert;
    end

endmodule

// File: rtl/rx_sync_pulse_gen.sv
module rx_sync_pulse_gen
    import rsync_pkg::*;
#(
    parameter int T1_FRAME_BITS = 193,
    parameter int E1_FRAME_BITS = 256,
    parameter int T1_SF_FRAMES  = 12,
    parameter int T1_ESF_FRAMES = 24,
    parameter int T1_SIG_PERIOD = 6,
    parameter int E1_MF_FRAMES  = 16,
    localparam int MAX_BITS = (T1_FRAME_BITS > E1_FRAME_BITS) ? T1_FRAME_BITS : E1_FRAME_BITS,
    localparam int BIT_W    = $clog2(MAX_BITS),
    localparam int FIDX_W   = $clog2(T1_ESF_FRAMES),
    localparam int MFIDX_W  = $clog2(E1_MF_FRAMES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               e1_mode,
    input  logic               esf_mode,
    input  logic [BIT_W-1:0]   bit_pos,
    input  logic [FIDX_W-1:0]  frame_idx,
    input  logic [MFIDX_W-1:0] cas_mf_index,
    input  logic [MFIDX_W-1:0] crc4_mf_index,
    input  logic               cfg_mf_mode,
    input  logic               cfg_skip,
    input  logic               cfg_sel2,
    input  logic               cfg_invert,
    input  logic               elastic_en,
    output logic               sync_out,
    output logic               mfsync_out
);

    line_t line;
    logic  frame_start, t1_mf_start, t1_sig_frame, e1_mf_start;
    logic  skip_active, skip_allow;
    logic  main_fire, main_wide, mf_fire;

    assign line = e1_mode ? LINE_E1 : LINE_T1;

    rsync_boundary_dec #(
        .BIT_W      (BIT_W),
        .FIDX_W     (FIDX_W),
        .MFIDX_W    (MFIDX_W),
        .SIG_PERIOD (T1_SIG_PERIOD),
        .SF_FRAMES  (T1_SF_FRAMES),
        .ESF_FRAMES (T1_ESF_FRAMES)
    ) u_dec (
        .bit_pos      (bit_pos),
        .frame_idx    (frame_idx),
        .esf_mode     (esf_mode),
        .cas_idx      (cas_mf_index),
        .crc_idx      (crc4_mf_index),
        .sel_crc4     (cfg_sel2),
        .frame_start  (frame_start),
        .t1_mf_start  (t1_mf_start),
        .t1_sig_frame (t1_sig_frame),
        .e1_mf_start  (e1_mf_start)
    );

    assign skip_active = (line == LINE_T1) && cfg_mf_mode && cfg_skip && !elastic_en;

    rsync_skip_fsm u_skip (
        .clk         (clk),
        .rst         (rst),
        .skip_cfg    (cfg_skip),
        .skip_active (skip_active),
        .mf_start    (t1_mf_start),
        .allow       (skip_allow)
    );

    always_comb begin
        main_fire = 1'b0;
        main_wide = 1'b0;
        mf_fire   = 1'b0;
        unique case (line)
            LINE_T1: begin
                main_fire = cfg_mf_mode ? (t1_mf_start && skip_allow) : frame_start;
                main_wide = !cfg_mf_mode && cfg_sel2 && t1_sig_frame;
                mf_fire   = t1_mf_start;
            end
            LINE_E1: begin
                main_fire = cfg_mf_mode ? e1_mf_start : frame_start;
                main_wide = 1'b0;
                mf_fire   = e1_mf_start;
            end
            default: ;
        endcase
    end

    rsync_pulse_fsm u_main (
        .clk       (clk),
        .rst       (rst),
        .fire      (main_fire),
        .wide      (main_wide),
        .invert    (cfg_invert),
        .pulse_out (sync_out)
    );

    rsync_pulse_fsm u_mf (
        .clk       (clk),
        .rst       (rst),
        .fire      (mf_fire),
        .wide      (1'b0),
        .invert    (1'b0),
        .pulse_out (mfsync_out)
    );

endmodule

// File: rtl/rsync_chk.sv
module rsync_chk #(
    parameter int BIT_W   = 8,
    parameter int MFIDX_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               e1_mode,
    input logic [BIT_W-1:0]   bit_pos,
    input logic [MFIDX_W-1:0] cas_mf_index,
    input logic [MFIDX_W-1:0] crc4_mf_index,
    input logic               cfg_mf_mode,
    input logic               cfg_sel2,
    input logic               cfg_invert,
    input logic               sync_out,
    input logic               mfsync_out
);

    logic started = 1'b0;
    always_ff @(posedge clk) started <= 1'b1;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        started && $past(rst) |-> (!mfsync_out && (sync_out == $past(cfg_invert))));

    // R2
    frame_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        started && $past(!rst) && $past(!cfg_mf_mode && bit_pos == '0)
        |-> (sync_out != $past(cfg_invert)));

    // R8
    mf_marker_chk: assert property (@(posedge clk) disable iff (rst)
        started && $past(!rst) &&
        $past(e1_mode && bit_pos == '0 &&
              (cfg_sel2 ? (crc4_mf_index == '0) : (cas_mf_index == '0)))
        |-> mfsync_out);

    // R8
    mf_origin_chk: assert property (@(posedge clk) disable iff (rst)
        started && mfsync_out |-> $past(bit_pos) == '0);

    // R9
    mf_no_invert_chk: assert property (@(posedge clk) disable iff (rst)
        started && $past(!rst) && $past(bit_pos != '0) |-> !mfsync_out);

endmodule

bind rx_sync_pulse_gen rsync_chk #(
    .BIT_W   (BIT_W),
    .MFIDX_W (MFIDX_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .e1_mode       (e1_mode),
    .bit_pos       (bit_pos),
    .cas_mf_index  (cas_mf_index),
    .crc4_mf_index (crc4_mf_index),
    .cfg_mf_mode   (cfg_mf_mode),
    .cfg_sel2      (cfg_sel2),
    .cfg_invert    (cfg_invert),
    .sync_out      (sync_out),
    .mfsync_out    (mfsync_out)
);

// File: tb/rx_sync_pulse_gen_tb.sv
module rx_sync_pulse_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       e1_mode = 1'b0, esf_mode = 1'b0;
    logic [7:0] bit_pos = 8'd50;
    logic [4:0] frame_idx = '0;
    logic [3:0] cas_mf_index = 4'd1, crc4_mf_index = 4'd1;
    logic       cfg_mf_mode = 1'b0, cfg_skip = 1'b0, cfg_sel2 = 1'b0;
    logic       cfg_invert = 1'b0, elastic_en = 1'b0;
    logic       sync_out, mfsync_out;

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    rx_sync_pulse_gen u_dut (
        .clk (clk), .rst (rst), .e1_mode (e1_mode), .esf_mode (esf_mode),
        .bit_pos (bit_pos), .frame_idx (frame_idx),
        .cas_mf_index (cas_mf_index), .crc4_mf_index (crc4_mf_index),
        .cfg_mf_mode (cfg_mf_mode), .cfg_skip (cfg_skip), .cfg_sel2 (cfg_sel2),
        .cfg_invert (cfg_invert), .elastic_en (elastic_en),
        .sync_out (sync_out), .mfsync_out (mfsync_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int bp, input int fi, input int cas, input int crc);
        @(negedge clk);
        bit_pos = 8'(bp); frame_idx = 5'(fi);
        cas_mf_index = 4'(cas); crc4_mf_index = 4'(crc);
        @(posedge clk);
        #2;
    endtask

    // Active-level main pulse at bit 0, 1, 2 and the marker at bit 0
    task automatic probe(input int fi, input int cas, input int crc,
                         output int m0, output int m1, output int m2, output int f0);
        step(0, fi, cas, crc); m0 = int'(sync_out ^ cfg_invert); f0 = int'(mfsync_out);
        step(1, fi, cas, crc); m1 = int'(sync_out ^ cfg_invert);
        step(2, fi, cas, crc); m2 = int'(sync_out ^ cfg_invert);
        step(50, fi, cas, crc);
    endtask

    task automatic config_set(input bit e1, input bit esf, input bit mf, input bit skip,
                              input bit sel2, input bit inv, input bit es);
        @(negedge clk);
        e1_mode = e1; esf_mode = esf; cfg_mf_mode = mf; cfg_skip = skip;
        cfg_sel2 = sel2; cfg_invert = inv; elastic_en = es;
        bit_pos = 8'd50;
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1; cfg_invert = 1'b0; bit_pos = 8'd0;
        @(posedge clk); #2;
        chk("R1 sync idle", int'(sync_out), 0);
        chk("R1 mfsync idle", int'(mfsync_out), 0);
        @(negedge clk); cfg_invert = 1'b1;
        @(posedge clk); #2;
        chk("R1 inverted idle", int'(sync_out), 1);
        @(negedge clk); rst = 1'b0; cfg_invert = 1'b0; bit_pos = 8'd50;
        @(posedge clk); #2;
    endtask

    task automatic t_frame_mode();
        int m0, m1, m2, f0;
        config_set(0, 0, 0, 0, 0, 0, 0);
        for (int fi = 1; fi < 4; fi++) begin
            probe(fi, 1, 1, m0, m1, m2, f0);
            chk("R2 T1 frame pulse", m0, 1);
            chk("R2 T1 one clock", m1, 0);
        end
        config_set(1, 0, 0, 0, 1, 0, 0);
        probe(0, 3, 3, m0, m1, m2, f0);
        chk("R2 E1 frame pulse", m0, 1);
        chk("R6 E1 no widen", m1, 0);
    endtask

    task automatic t_t1_multiframe();
        int m0, m1, m2, f0;
        config_set(0, 0, 1, 0, 0, 0, 0);
        for (int fi = 0; fi < 12; fi++) begin
            probe(fi, 1, 1, m0, m1, m2, f0);
            chk("R3 T1 mf pulse", m0, (fi == 0) ? 1 : 0);
            chk("R8 T1 marker", f0, (fi == 0) ? 1 : 0);
        end
    endtask

    task automatic t_skip();
        int m0, m1, m2, f0;
        int exp_seq[3] = '{1, 0, 1};
        config_set(0, 0, 1, 1, 0, 0, 0);
        for (int k = 0; k < 3; k++) begin
            probe(0, 1, 1, m0, m1, m2, f0);
            chk("R4 alternate mf", m0, exp_seq[k]);
            probe(4, 1, 1, m0, m1, m2, f0);
            chk("R4 mid frame quiet", m0, 0);
        end
        config_set(0, 0, 1, 0, 0, 0, 0);
        config_set(0, 0, 1, 1, 0, 0, 0);
        probe(0, 1, 1, m0, m1, m2, f0);
        chk("R4 re-arm emits", m0, 1);
        config_set(0, 0, 1, 1, 0, 0, 1);
        for (int k = 0; k < 3; k++) begin
            probe(0, 1, 1, m0, m1, m2, f0);
            chk("R5 elastic every mf", m0, 1);
        end
    endtask

    task automatic t_wide();
        int m0, m1, m2, f0;
        int sf_frames[3]  = '{5, 11, 4};
        int sf_exp[3]     = '{1, 1, 0};
        config_set(0, 0, 0, 0, 1, 0, 0);
        for (int k = 0; k < 3; k++) begin
            probe(sf_frames[k], 1, 1, m0, m1, m2, f0);
            chk("R6 SF start", m0, 1);
            chk("R6 SF second clock", m1, sf_exp[k]);
            chk("R6 SF ends", m2, 0);
        end
        probe(17, 1, 1, m0, m1, m2, f0);
        chk("R6 SF frame 17 narrow", m1, 0);
        config_set(0, 1, 0, 0, 1, 0, 0);
        probe(17, 1, 1, m0, m1, m2, f0);
        chk("R6 ESF frame 17 wide", m1, 1);
        probe(23, 1, 1, m0, m1, m2, f0);
        chk("R6 ESF frame 23 wide", m1, 1);
        chk("R6 ESF frame 23 ends", m2, 0);
        config_set(0, 1, 0, 0, 0, 0, 0);
        probe(5, 1, 1, m0, m1, m2, f0);
        chk("R6 sel2 off narrow", m1, 0);
    endtask

    task automatic t_e1_mf();
        int m0, m1, m2, f0;
        config_set(1, 0, 1, 0, 0, 0, 0);
        probe(0, 0, 5, m0, m1, m2, f0);
        chk("R7 CAS boundary", m0, 1);
        probe(0, 3, 0, m0, m1, m2, f0);
        chk("R7 CRC-4 ignored under CAS", m0, 0);
        config_set(1, 0, 1, 0, 1, 0, 0);
        probe(0, 3, 0, m0, m1, m2, f0);
        chk("R7 CRC-4 boundary", m0, 1);
        probe(0, 0, 5, m0, m1, m2, f0);
        chk("R7 CAS ignored under CRC-4", m0, 0);
        config_set(1, 0, 0, 0, 1, 0, 0);
        probe(0, 0, 7, m0, m1, m2, f0);
        chk("R8 marker CRC-4 sel, CAS start", f0, 0);
        chk("R2 E1 frame pulse still", m0, 1);
        probe(0, 7, 0, m0, m1, m2, f0);
        chk("R8 marker CRC-4 sel", f0, 1);
        config_set(1, 0, 0, 0, 0, 0, 0);
        probe(0, 0, 7, m0, m1, m2, f0);
        chk("R8 marker CAS sel", f0, 1);
    endtask

    task automatic t_invert();
        int m0, m1, m2, f0;
        config_set(0, 0, 0, 0, 0, 1, 0);
        step(50, 2, 1, 1);
        chk("R9 idle high", int'(sync_out), 1);
        step(0, 2, 1, 1);
        chk("R9 active low", int'(sync_out), 0);
        step(1, 2, 1, 1);
        chk("R9 back high", int'(sync_out), 1);
        probe(0, 1, 1, m0, m1, m2, f0);
        chk("R9 marker not inverted", f0, 1);
        config_set(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_frame_mode();
        t_t1_multiframe();
        t_skip();
        t_wide();
        t_e1_mf();
        t_invert();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule